// File: doc/BRIEF.md
# Speculative Load Tracking Table

This block supports data speculation, where a compiler hoists a load above stores that may write the same bytes. When such an advanced load executes, the block records which destination register it filled, the byte address it read and the width of the access. Every later store probes the table. Any entry whose byte range overlaps the store's byte range is dropped. Before the loaded value is trusted, a check names the destination register. A surviving entry confirms the value. A missing entry tells the pipeline to run recovery code.

The check is answered combinationally, in the same cycle as the consuming instruction, from the table contents at the start of that cycle. A check may optionally retire the entry on a hit. A context-switch input empties the whole table at once. Entries are fully associative and tagged by register number. A register that is loaded again reuses its own entry. Otherwise a free entry is taken, and when the table is full a rotating victim pointer chooses the entry to replace.

Top module: `spec_load_table`

## Requirements
- R1: After reset no entry is valid, so any check misses: `chk_recover` is 1 and `chk_hit` is 0.
- R2: An advanced load (`ld_valid`) records its register, and a check of that register in any later cycle hits until something removes the entry. The check result is combinational on the check inputs and reflects the table as it stood at the start of the cycle.
- R3: The size codes 0, 1, 2 and 3 mean 1, 2, 4 and 8 bytes, starting at the given byte address. A store removes an entry when the two byte ranges overlap, meaning neither range ends before the other begins. A store to a range that only touches or misses the entry's range leaves the entry intact.
- R4: A single store removes every overlapping entry in the same cycle and leaves the non-overlapping entries valid.
- R5: When `chk_valid` is 1, exactly one of `chk_hit` and `chk_recover` is 1. When it is 0, both are 0. A hit with `chk_clear`=1 removes the entry. A hit with `chk_clear`=0 leaves it valid.
- R6: An advanced load to a register that already has a valid entry overwrites that entry. The old address is no longer tracked, and at most one valid entry exists per register.
- R7: A load to a new register fills the lowest-numbered free entry. When all entries are valid, it replaces the entry selected by a rotating pointer. The pointer starts at entry 0 after reset and advances by one, with wrap, on each such replacement.
- R8: In a cycle where a store probe or a check-with-clear coincides with an advanced load, the removal is applied first and the load's new entry survives.
- R9: `flush_all` clears every entry. An advanced load in the same cycle is discarded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| flush_all | input | 1 | Clear the whole table (context switch) |
| ld_valid | input | 1 | Advanced load executes this cycle |
| ld_reg | input | REG_W | Destination register of the advanced load |
| ld_addr | input | ADDR_W | Byte address read by the load |
| ld_size | input | 2 | Load size code (0:1, 1:2, 2:4, 3:8 bytes) |
| st_valid | input | 1 | Store probe this cycle |
| st_addr | input | ADDR_W | Byte address written by the store |
| st_size | input | 2 | Store size code, same encoding |
| chk_valid | input | 1 | Check of a speculative value this cycle |
| chk_reg | input | REG_W | Register being checked |
| chk_clear | input | 1 | Remove the entry on a hit |
| chk_hit | output | 1 | Speculative value confirmed |
| chk_recover | output | 1 | No valid entry: recovery required |

## Verification
A corrupted valid bit, tag or range shows up at the ports only when that register is checked again. An entry that was wrongly kept shows as a hit where a miss is due. An entry that was wrongly dropped shows as a spurious recovery. A wrong victim pointer shows as the wrong register surviving after the table fills. The bench keeps the register pool small and issues checks in most cycles, so a wrong entry is usually exposed within a few cycles of the mistake. Directed sequences cover range boundaries that touch but do not overlap, multi-entry invalidation, same-cycle orderings and pointer wrap.

// File: rtl/slt_pkg.sv
package slt_pkg;

   // access width code: 0:1B 1:2B 2:4B 3:8B
   typedef logic [1:0] acc_size_t;

   localparam acc_size_t SZ_BYTE  = 2'd0;
   localparam acc_size_t SZ_HALF  = 2'd1;
   localparam acc_size_t SZ_WORD  = 2'd2;
   localparam acc_size_t SZ_DWORD = 2'd3;

   function automatic logic [3:0] size_bytes(input acc_size_t code);
      return 4'd1 << code;
   endfunction

endpackage

// File: rtl/slt_entry.sv
module slt_entry #(
   parameter int REG_W  = 7,
   parameter int ADDR_W = 40
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              kill_all,
   input  logic              wr_en,
   input  logic [REG_W-1:0]  wr_tag,
   input  logic [ADDR_W:0]   wr_lo,
   input  logic [ADDR_W:0]   wr_hi,
   input  logic              probe_en,
   input  logic [ADDR_W:0]   probe_lo,
   input  logic [ADDR_W:0]   probe_hi,
   input  logic              drop_en,
   input  logic [REG_W-1:0]  look_tag,
   input  logic [REG_W-1:0]  ins_tag,
   output logic              e_valid,
   output logic [REG_W-1:0]  e_tag,
   output logic              look_match,
   output logic              ins_match,
   output logic              probe_hit
);

   logic [ADDR_W:0] lo_q;
   logic [ADDR_W:0] hi_q;

   always_comb begin
      look_match = e_valid && (e_tag == look_tag);
      ins_match  = e_valid && (e_tag == ins_tag);
      probe_hit  = probe_en && e_valid && (probe_lo <= hi_q) && (lo_q <= probe_hi);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         e_valid <= 1'b0;
         e_tag   <= '0;
         lo_q    <= '0;
         hi_q    <= '0;
      end else if (kill_all) begin
         e_valid <= 1'b0;
      end else if (wr_en) begin
         e_valid <= 1'b1;
         e_tag   <= wr_tag;
         lo_q    <= wr_lo;
         hi_q    <= wr_hi;
      end else if (probe_hit || drop_en) begin
         e_valid <= 1'b0;
      end
   end

endmodule

// File: rtl/slt_alloc.sv
module slt_alloc #(
   parameter int ENTRIES = 32
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               ins_fire,
   input  logic [ENTRIES-1:0] valid_vec,
   input  logic [ENTRIES-1:0] same_vec,
   output logic [ENTRIES-1:0] wr_vec
);

   localparam int PTR_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
   localparam bit POW2  = ((1 << PTR_W) == ENTRIES);

   logic [PTR_W-1:0]   rr_q;
   logic [PTR_W-1:0]   rr_nxt;
   logic [ENTRIES-1:0] free_oh;
   logic [ENTRIES-1:0] rr_oh;
   logic               free_found;
   logic               use_rr;

   always_comb begin
      free_oh    = '0;
      free_found = 1'b0;
      for (int i = 0; i < ENTRIES; i++) begin
         if (!valid_vec[i] && !free_found) begin
            free_oh[i] = 1'b1;
            free_found = 1'b1;
         end
      end
      rr_oh       = '0;
      rr_oh[rr_q] = 1'b1;
   end

   always_comb begin
      use_rr = ins_fire && !(|same_vec) && !free_found;
      if (!ins_fire)        wr_vec = '0;
      else if (|same_vec)   wr_vec = same_vec;
      else if (free_found)  wr_vec = free_oh;
      else                  wr_vec = rr_oh;
   end

   generate
      if (POW2) begin : g_wrap_free
         assign rr_nxt = rr_q + 1'b1;
      end else begin : g_wrap_cmp
         assign rr_nxt = (rr_q == PTR_W'(ENTRIES - 1)) ? '0 : rr_q + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)      rr_q <= '0;
      else if (use_rr) rr_q <= rr_nxt;
   end

endmodule

// File: rtl/spec_load_table.sv
module spec_load_table #(
   parameter int ENTRIES = 32,
   parameter int REG_W   = 7,
   parameter int ADDR_W  = 40
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              flush_all,
   input  logic              ld_valid,
   input  logic [REG_W-1:0]  ld_reg,
   input  logic [ADDR_W-1:0] ld_addr,
   input  logic [1:0]        ld_size,
   input  logic              st_valid,
   input  logic [ADDR_W-1:0] st_addr,
   input  logic [1:0]        st_size,
   input  logic              chk_valid,
   input  logic [REG_W-1:0]  chk_reg,
   input  logic              chk_clear,
   output logic              chk_hit,
   output logic              chk_recover
);
   import slt_pkg::*;

   localparam int EXT_W = ADDR_W + 1;

   generate
      if (ENTRIES < 2 || ENTRIES > 256) begin : g_bad_entries
         $error("spec_load_table: ENTRIES out of range");
      end
      if (REG_W < 1 || ADDR_W < 4) begin : g_bad_width
         $error("spec_load_table: width parameter out of range");
      end
   endgenerate

   logic [EXT_W-1:0]         ld_lo, ld_hi, st_lo, st_hi;
   logic [ENTRIES-1:0]       valid_vec, look_vec, same_vec, probe_vec, wr_vec, drop_vec;
   logic [ENTRIES*REG_W-1:0] tag_flat;
   logic                     ins_fire;
   logic                     look_any;

   always_comb begin
      ld_lo    = {1'b0, ld_addr};
      ld_hi    = ld_lo + EXT_W'(size_bytes(acc_size_t'(ld_size))) - 1'b1;
      st_lo    = {1'b0, st_addr};
      st_hi    = st_lo + EXT_W'(size_bytes(acc_size_t'(st_size))) - 1'b1;
      ins_fire = ld_valid && !flush_all;
      look_any = |look_vec;
      drop_vec = (chk_valid && chk_clear) ? look_vec : '0;
      chk_hit     = chk_valid && look_any;
      chk_recover = chk_valid && !look_any;
   end

   slt_alloc #(.ENTRIES(ENTRIES)) u_alloc (
      .clk       (clk),
      .rst_n     (rst_n),
      .ins_fire  (ins_fire),
      .valid_vec (valid_vec),
      .same_vec  (same_vec),
      .wr_vec    (wr_vec)
   );

   generate
      for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
         slt_entry #(.REG_W(REG_W), .ADDR_W(ADDR_W)) u_ent (
            .clk        (clk),
            .rst_n      (rst_n),
            .kill_all   (flush_all),
            .wr_en      (wr_vec[g]),
            .wr_tag     (ld_reg),
            .wr_lo      (ld_lo),
            .wr_hi      (ld_hi),
            .probe_en   (st_valid),
            .probe_lo   (st_lo),
            .probe_hi   (st_hi),
            .drop_en    (drop_vec[g]),
            .look_tag   (chk_reg),
            .ins_tag    (ld_reg),
            .e_valid    (valid_vec[g]),
            .e_tag      (tag_flat[g*REG_W +: REG_W]),
            .look_match (look_vec[g]),
            .ins_match  (same_vec[g]),
            .probe_hit  (probe_vec[g])
         );
      end
   endgenerate

endmodule

module slt_chk #(
   parameter int ENTRIES = 32,
   parameter int REG_W   = 7
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic                     flush_all,
   input logic                     ld_valid,
   input logic [REG_W-1:0]         ld_reg,
   input logic                     st_valid,
   input logic                     chk_valid,
   input logic [REG_W-1:0]         chk_reg,
   input logic                     chk_clear,
   input logic                     chk_hit,
   input logic                     chk_recover,
   input logic [ENTRIES-1:0]       valid_vec,
   input logic [ENTRIES*REG_W-1:0] tag_flat
);

   function automatic logic [ENTRIES-1:0] holders(input logic [REG_W-1:0] r,
                                                  input logic [ENTRIES-1:0] v,
                                                  input logic [ENTRIES*REG_W-1:0] t);
      logic [ENTRIES-1:0] m;
      for (int i = 0; i < ENTRIES; i++) m[i] = v[i] && (t[i*REG_W +: REG_W] == r);
      return m;
   endfunction

   // R5
   hit_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(chk_hit && chk_recover));

   // R5
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !chk_valid |-> (!chk_hit && !chk_recover));

   // R2
   load_records_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ld_valid && !flush_all) |=> (|holders($past(ld_reg), valid_vec, tag_flat)));

   // R9
   flush_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
      flush_all |=> (valid_vec == '0));

   // R6
   one_per_reg_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(holders(chk_reg, valid_vec, tag_flat)));

   // R5
   clear_removes_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (chk_valid && chk_clear && chk_hit && !(ld_valid && ld_reg == chk_reg))
      |=> !(|holders($past(chk_reg), valid_vec, tag_flat)));

   // R5
   keep_no_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (chk_valid && !chk_clear && chk_hit && !flush_all && !st_valid && !ld_valid)
      |=> (|holders($past(chk_reg), valid_vec, tag_flat)));

endmodule

bind spec_load_table slt_chk #(.ENTRIES(ENTRIES), .REG_W(REG_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .flush_all   (flush_all),
   .ld_valid    (ld_valid),
   .ld_reg      (ld_reg),
   .st_valid    (st_valid),
   .chk_valid   (chk_valid),
   .chk_reg     (chk_reg),
   .chk_clear   (chk_clear),
   .chk_hit     (chk_hit),
   .chk_recover (chk_recover),
   .valid_vec   (valid_vec),
   .tag_flat    (tag_flat)
);

// File: tb/spec_load_table_bench.sv
module spec_load_table_bench;

   localparam int N  = 32;
   localparam int RW = 7;
   localparam int AW = 40;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          flush_all = 1'b0;
   logic          ld_valid = 1'b0;
   logic [RW-1:0] ld_reg = '0;
   logic [AW-1:0] ld_addr = '0;
   logic [1:0]    ld_size = '0;
   logic          st_valid = 1'b0;
   logic [AW-1:0] st_addr = '0;
   logic [1:0]    st_size = '0;
   logic          chk_valid = 1'b0;
   logic [RW-1:0] chk_reg = '0;
   logic          chk_clear = 1'b0;
   logic          chk_hit;
   logic          chk_recover;

   int    checks = 0;
   int    errors = 0;
   bit    done = 1'b0;
   string phase = "R1";

   // behavioural model
   bit      m_val [N];
   int      m_tag [N];
   longint  m_lo  [N];
   longint  m_hi  [N];
   int      m_ptr;

   always #2.5 clk = ~clk;

   spec_load_table #(.ENTRIES(N), .REG_W(RW), .ADDR_W(AW)) u_spec_load_table (
      .clk(clk), .rst_n(rst_n), .flush_all(flush_all),
      .ld_valid(ld_valid), .ld_reg(ld_reg), .ld_addr(ld_addr), .ld_size(ld_size),
      .st_valid(st_valid), .st_addr(st_addr), .st_size(st_size),
      .chk_valid(chk_valid), .chk_reg(chk_reg), .chk_clear(chk_clear),
      .chk_hit(chk_hit), .chk_recover(chk_recover)
   );

   function automatic bit m_has(int r);
      for (int i = 0; i < N; i++) if (m_val[i] && m_tag[i] == r) return 1'b1;
      return 1'b0;
   endfunction

   task automatic check(input string req, input bit got, input bit exp, input string what);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s %s actual=%0b expected=%0b at %0t", req, what, got, exp, $time);
      end
   endtask

   task automatic model_step();
      bit pre [N];
      int hit_i, free_i, v;
      longint slo, shi;
      if (flush_all) begin
         for (int i = 0; i < N; i++) m_val[i] = 1'b0;
         return;
      end
      for (int i = 0; i < N; i++) pre[i] = m_val[i];
      hit_i = -1; free_i = -1;
      for (int i = 0; i < N; i++) begin
         if (pre[i] && m_tag[i] == int'(ld_reg) && hit_i < 0) hit_i = i;
         if (!pre[i] && free_i < 0) free_i = i;
      end
      slo = longint'(st_addr);
      shi = slo + (longint'(1) << st_size) - 1;
      for (int i = 0; i < N; i++) begin
         if (st_valid && pre[i] && !(shi < m_lo[i] || m_hi[i] < slo)) m_val[i] = 1'b0;
         if (chk_valid && chk_clear && pre[i] && m_tag[i] == int'(chk_reg)) m_val[i] = 1'b0;
      end
      if (ld_valid) begin
         if (hit_i >= 0) v = hit_i;
         else if (free_i >= 0) v = free_i;
         else begin
            v = m_ptr;
            m_ptr = (m_ptr + 1) % N;
         end
         m_val[v] = 1'b1;
         m_tag[v] = int'(ld_reg);
         m_lo[v]  = longint'(ld_addr);
         m_hi[v]  = longint'(ld_addr) + (longint'(1) << ld_size) - 1;
      end
   endtask

   task automatic idle_inputs();
      flush_all = 0; ld_valid = 0; st_valid = 0; chk_valid = 0; chk_clear = 0;
   endtask

   // inputs already driven at a falling edge; compare, advance model, move to next falling edge
   task automatic tick();
      bit e;
      #1;
      e = chk_valid && m_has(int'(chk_reg));
      check(phase, chk_hit, e, "chk_hit");
      check(phase, chk_recover, chk_valid && !e, "chk_recover");
      if (rst_n) model_step();
      @(negedge clk);
      idle_inputs();
   endtask

   task automatic do_load(input int r, input longint a, input int s);
      ld_valid = 1; ld_reg = RW'(r); ld_addr = AW'(a); ld_size = 2'(s); tick();
   endtask
   task automatic do_store(input longint a, input int s);
      st_valid = 1; st_addr = AW'(a); st_size = 2'(s); tick();
   endtask
   task automatic do_check(input int r, input bit clr);
      chk_valid = 1; chk_reg = RW'(r); chk_clear = clr; tick();
   endtask

   initial begin
      #(200000 * 5);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < N; i++) begin
         m_val[i] = 0; m_tag[i] = 0; m_lo[i] = 0; m_hi[i] = 0;
      end
      m_ptr = 0;
      repeat (4) @(negedge clk);
      rst_n = 1;

      // R1: empty after reset
      phase = "R1";
      do_check(5, 0);
      do_check(0, 0);
      // R5: no check, outputs quiet
      phase = "R5";
      tick();

      // R2: record and confirm
      phase = "R2";
      do_load(3, 'h100, 2);
      do_check(3, 0);
      // R5: check without clear keeps entry
      phase = "R5";
      do_check(3, 0);

      // R3: range boundaries of [0x100,0x103]
      phase = "R3";
      do_store('h104, 0); do_check(3, 0);
      do_store('h0FF, 0); do_check(3, 0);
      do_store('h0F8, 3); do_check(3, 0);
      do_store('h102, 1); do_check(3, 0);

      // R4: one store removes several entries
      phase = "R4";
      do_load(1, 'h200, 3);
      do_load(2, 'h204, 1);
      do_load(4, 'h300, 0);
      do_store('h204, 2);
      do_check(1, 0); do_check(2, 0); do_check(4, 0);

      // R5: check with clear removes a hit
      phase = "R5";
      do_check(4, 1);
      do_check(4, 0);

      // R6: overwrite on same register
      phase = "R6";
      do_load(7, 'h400, 0);
      do_load(7, 'h500, 0);
      do_store('h400, 0); do_check(7, 0);
      do_store('h500, 0); do_check(7, 0);

      // R8: removal applied before insert
      phase = "R8";
      ld_valid = 1; ld_reg = 9; ld_addr = 'h600; ld_size = 0;
      st_valid = 1; st_addr = 'h600; st_size = 0;
      tick();
      do_check(9, 0);
      ld_valid = 1; ld_reg = 9; ld_addr = 'h700; ld_size = 0;
      chk_valid = 1; chk_reg = 9; chk_clear = 1;
      tick();
      do_check(9, 0);

      // R9: flush clears all and drops a same-cycle load
      phase = "R9";
      do_load(10, 'h800, 0);
      do_load(11, 'h900, 0);
      flush_all = 1; ld_valid = 1; ld_reg = 12; ld_addr = 'hA00; ld_size = 0;
      tick();
      do_check(10, 0); do_check(11, 0); do_check(12, 0);

      // R7: fill, then rotate victims from entry 0
      phase = "R7";
      for (int i = 0; i < N; i++) do_load(20 + i, 'h1000 + 16 * i, 0);
      do_load(60, 'h2000, 0);
      do_check(20, 0); do_check(21, 0);
      do_load(61, 'h2100, 0);
      do_check(21, 0); do_check(22, 0); do_check(60, 0);

      // R2: random traffic against the model
      phase = "R2";
      for (int c = 0; c < 6000; c++) begin
         ld_valid  = ($urandom_range(0, 2) == 0);
         ld_reg    = RW'($urandom_range(0, 40));
         ld_addr   = AW'($urandom_range(0, 255));
         ld_size   = 2'($urandom_range(0, 3));
         st_valid  = ($urandom_range(0, 3) == 0);
         st_addr   = AW'($urandom_range(0, 255));
         st_size   = 2'($urandom_range(0, 3));
         chk_valid = ($urandom_range(0, 3) != 0);
         chk_reg   = RW'($urandom_range(0, 40));
         chk_clear = ($urandom_range(0, 2) == 0);
         flush_all = ($urandom_range(0, 199) == 0);
         tick();
      end

      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule